// File: doc/BRIEF.md
# Vector element loop sequencer

This block sits between instruction decode and issue. It takes one decoded instruction that carries a vector prefix and turns it into a run of element operations, one for each element index. Each element reaches issue as if it were its own sequential instruction, and elements keep program order. The current element index, or step, is not held in a private counter. It lives in a 32-bit architectural loop-state register, so the loop acts as a sub-PC that can be stopped and resumed.

For each element, every operand tagged as vector gets the step added to its register number. Operands tagged as scalar keep their number. The implicit condition-register operand is handled the same way: only its vector/scalar tag counts. When a trap is taken between two elements, the loop state goes into a save register at the same moment PC and MSR go to theirs. A trap return copies it back, and the re-presented instruction continues from the saved step. Prefixed opcodes outside the vector-capable set are rejected with an illegal-instruction signal and never loop.

Both registers can be reached through a special-register port:
- The loop state is at number 704 and needs no privilege.
- The save register is at number 720 and needs privilege.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset the loop state and the save register both read 0, and no element is offered to issue.
- R2: With the loop-state layout step in bits 6:0 and VL in bits 13:7, a prefixed legal instruction with VL>0 offers elements whose step goes up by one from the stored step until it reaches VL-1. `dec_ready_o` rises in the cycle the last element is accepted.
- R3: In an element, an operand whose tag bit in `dec_vec_i` is 1 gets register number (base+step) mod 128. An operand whose tag is 0 keeps its base number. This applies to all slots, including the condition-register slot.
- R4: While `iss_valid_o` is high and `iss_ready_i` is low, the offered element stays stable and the step does not advance.
- R5: A prefixed legal instruction with VL=0 retires (`dec_ready_o` high) in its first cycle with `iss_valid_o` low.
- R6: After the last element is accepted, the step field reads 0. The VL field is unchanged.
- R7: With a prefixed instruction whose `dec_kind_i` is not one of the vector-capable codes, `illegal_o` and `dec_ready_o` are raised, no element is issued and the step is unchanged. The vector-capable codes are 0 (arithmetic), 1 (load), 2 (store) and 3 (special-register move). Examples of other codes are 4 (branch), 5 (set-length), 6 (MSR write), 7 (MSR read) and 8..15.
- R8: An unprefixed instruction is offered once with its register numbers unchanged and `iss_step_o`=0. It retires on acceptance and leaves the loop state untouched.
- R9: On `exc_i`, the save register takes the loop state, which holds the step of the first element not yet accepted. The live step is cleared and VL is kept.
- R10: On `rfi_i`, the loop state takes the save register's value, so a re-presented instruction resumes at the saved step.
- R11: Special register 704 can be read and written without privilege, and all 32 bits hold what was written.
- R12: Special register 720 needs `spr_priv_i`. An unprivileged access raises `spr_err_o`, a write is ignored and a read returns 0.
- R13: Priority, highest first: `exc_i`, then `rfi_i`, then a special-register write, then a step advance. During `exc_i` or `rfi_i` no element is offered and nothing retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decoded instruction present |
| dec_prefixed_i | input | 1 | Instruction carries the vector prefix |
| dec_kind_i | input | 4 | Opcode class code |
| dec_reg_i | input | NUM_OPS*REG_W | Operand base register numbers, slot 3 is the implicit CR |
| dec_vec_i | input | NUM_OPS | Per-slot vector tag |
| dec_ready_o | output | 1 | Instruction retired, PC may advance |
| illegal_o | output | 1 | Prefixed opcode is not vector-capable |
| iss_valid_o | output | 1 | Element offered to issue |
| iss_ready_i | input | 1 | Issue accepts the element |
| iss_reg_o | output | NUM_OPS*REG_W | Element register numbers |
| iss_step_o | output | REG_W | Element index |
| exc_i | input | 1 | Trap taken between elements |
| rfi_i | input | 1 | Trap return |
| spr_we_i | input | 1 | Special-register write |
| spr_re_i | input | 1 | Special-register read |
| spr_num_i | input | 10 | Special-register number |
| spr_priv_i | input | 1 | Access is privileged |
| spr_wdata_i | input | 32 | Write data |
| spr_rdata_o | output | 32 | Read data |
| spr_err_o | output | 1 | Privilege violation |

## Verification
On every cycle, assertions check the following:
- the step holds while an offer stalls;
- the step moves up by exactly one on a non-final acceptance and returns to 0 after the final one;
- a trap blocks any offer or retirement;
- the save register captures the prior loop state on a trap, and the loop state returns from it on trap return;
- an unprivileged write leaves the save register alone.

Other behaviours need the bench's scenarios:
- a full run of element register numbers, including the wrap at 128;
- a resume from a mid-loop trap that continues at the right step;
- zero-length retirement;
- the rejection of each non-capable code;
- the stored bits of the loop-state register read back through the port.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int XLEN    = 32;
  localparam int KIND_W  = 4;
  localparam int SPRN_W  = 10;
  localparam logic [SPRN_W-1:0] SPR_LOOP = 10'd704;
  localparam logic [SPRN_W-1:0] SPR_SAVE = 10'd720;
  // vector-capable kind codes: arith, load, store, spr move
  localparam logic [(1<<KIND_W)-1:0] VEC_OK_MASK = 16'h000F;
endpackage

// File: rtl/vls_kind_chk.sv
module vls_kind_chk
  import vls_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  output logic              legal_o
);
  assign legal_o = VEC_OK_MASK[kind_i];
endmodule

// File: rtl/vls_reg_gen.sv
module vls_reg_gen #(
  parameter int NUM_OPS = 4,
  parameter int REG_W   = 7
) (
  input  logic                     en_i,
  input  logic [REG_W-1:0]         step_i,
  input  logic [NUM_OPS*REG_W-1:0] base_i,
  input  logic [NUM_OPS-1:0]       vec_i,
  output logic [NUM_OPS*REG_W-1:0] reg_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic [REG_W-1:0] base;
    assign base = base_i[g*REG_W +: REG_W];
    // sum truncates to REG_W: modulo register-file size
    assign reg_o[g*REG_W +: REG_W] = (en_i && vec_i[g]) ? base + step_i : base;
  end
endmodule

// File: rtl/vls_state.sv
module vls_state
  import vls_pkg::*;
#(
  parameter int REG_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic              exc_i,
  input  logic              rfi_i,
  input  logic              spr_we_i,
  input  logic              spr_re_i,
  input  logic [SPRN_W-1:0] spr_num_i,
  input  logic              spr_priv_i,
  input  logic [XLEN-1:0]   spr_wdata_i,
  output logic [XLEN-1:0]   spr_rdata_o,
  output logic              spr_err_o,
  output logic [REG_W-1:0]  step_o,
  output logic [REG_W-1:0]  vl_o
);
  logic [XLEN-1:0] st_q, save_q;
  logic hit_loop, hit_save, save_ok;

  assign hit_loop = spr_num_i == SPR_LOOP;
  assign hit_save = spr_num_i == SPR_SAVE;
  assign save_ok  = hit_save && spr_priv_i;

  assign step_o = st_q[REG_W-1:0];
  assign vl_o   = st_q[2*REG_W-1:REG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      save_q <= '0;
    end else if (exc_i) begin
      save_q            <= st_q;
      st_q[REG_W-1:0]   <= '0;
    end else if (rfi_i) begin
      st_q <= save_q;
    end else begin
      if (spr_we_i && save_ok) save_q <= spr_wdata_i;
      if (spr_we_i && hit_loop) st_q <= spr_wdata_i;
      else if (clr_i) st_q[REG_W-1:0] <= '0;
      else if (adv_i) st_q[REG_W-1:0] <= step_o + REG_W'(1);
    end
  end

  always_comb begin
    spr_rdata_o = '0;
    if (spr_re_i && hit_loop) spr_rdata_o = st_q;
    else if (spr_re_i && save_ok) spr_rdata_o = save_q;
  end
  assign spr_err_o = (spr_we_i || spr_re_i) && hit_save && !spr_priv_i;

  p_save_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> save_q == $past(st_q));
  p_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !exc_i) |=> st_q == $past(save_q));
  p_priv_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_we_i && hit_save && !spr_priv_i && !exc_i && !rfi_i) |=> $stable(save_q));
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
  import vls_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int REG_W   = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dec_valid_i,
  input  logic                     dec_prefixed_i,
  input  logic [3:0]               dec_kind_i,
  input  logic [NUM_OPS*REG_W-1:0] dec_reg_i,
  input  logic [NUM_OPS-1:0]       dec_vec_i,
  output logic                     dec_ready_o,
  output logic                     illegal_o,
  output logic                     iss_valid_o,
  input  logic                     iss_ready_i,
  output logic [NUM_OPS*REG_W-1:0] iss_reg_o,
  output logic [REG_W-1:0]         iss_step_o,
  input  logic                     exc_i,
  input  logic                     rfi_i,
  input  logic                     spr_we_i,
  input  logic                     spr_re_i,
  input  logic [9:0]               spr_num_i,
  input  logic                     spr_priv_i,
  input  logic [31:0]              spr_wdata_i,
  output logic [31:0]              spr_rdata_o,
  output logic                     spr_err_o
);
  logic [REG_W-1:0] step, vl;
  logic [REG_W:0]   step_p1;
  logic legal, go, bad, empty, last, accept, adv, clr;

  vls_kind_chk u_kind (.kind_i(dec_kind_i), .legal_o(legal));

  assign go      = dec_valid_i && !exc_i && !rfi_i;
  assign bad     = dec_prefixed_i && !legal;
  assign empty   = dec_prefixed_i && legal && (vl == '0);
  assign step_p1 = {1'b0, step} + (REG_W+1)'(1);
  assign last    = step_p1 >= {1'b0, vl};

  assign iss_valid_o = go && !bad && !empty;
  assign accept      = iss_valid_o && iss_ready_i;
  assign dec_ready_o = go && (bad || empty || (accept && (!dec_prefixed_i || last)));
  assign illegal_o   = go && bad;
  assign adv         = accept && dec_prefixed_i && !last;
  assign clr         = accept && dec_prefixed_i && last;
  assign iss_step_o  = dec_prefixed_i ? step : '0;

  vls_reg_gen #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) u_regs (
    .en_i(dec_prefixed_i), .step_i(step), .base_i(dec_reg_i),
    .vec_i(dec_vec_i), .reg_o(iss_reg_o)
  );

  vls_state #(.REG_W(REG_W)) u_state (
    .clk_i, .rst_ni, .adv_i(adv), .clr_i(clr), .exc_i, .rfi_i,
    .spr_we_i, .spr_re_i, .spr_num_i, .spr_priv_i, .spr_wdata_i,
    .spr_rdata_o, .spr_err_o, .step_o(step), .vl_o(vl)
  );

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i && !spr_we_i) |=> $stable(step));
  p_step_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_prefixed_i && !last && !spr_we_i) |=> step == $past(step) + REG_W'(1));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_prefixed_i && last && !spr_we_i) |=> step == '0);
  p_illegal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!iss_valid_o && dec_ready_o));
  p_exc_block_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |-> (!iss_valid_o && !dec_ready_o));
endmodule

// File: tb/vec_loop_seq_tb_top.sv
module vec_loop_seq_tb_top;
  localparam int NOPS = 4;
  localparam int RW = 7;

  logic clk = 0, rst_ni = 0;
  logic dec_valid_i = 0, dec_prefixed_i = 0;
  logic [3:0] dec_kind_i = 0;
  logic [NOPS*RW-1:0] dec_reg_i = 0;
  logic [NOPS-1:0] dec_vec_i = 0;
  logic dec_ready_o, illegal_o, iss_valid_o;
  logic iss_ready_i = 0;
  logic [NOPS*RW-1:0] iss_reg_o;
  logic [RW-1:0] iss_step_o;
  logic exc_i = 0, rfi_i = 0, spr_we_i = 0, spr_re_i = 0, spr_priv_i = 0;
  logic [9:0] spr_num_i = 0;
  logic [31:0] spr_wdata_i = 0, spr_rdata_o;
  logic spr_err_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_state = 0, m_save = 0;

  always #4 clk = ~clk;

  vec_loop_seq dut_i (.clk_i(clk), .*);

  task automatic check(input string rid, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rid, what, act, exp);
    end
  endtask

  task automatic spr_wr(input logic [9:0] num, input logic [31:0] d, input logic priv);
    @(negedge clk);
    spr_we_i = 1; spr_num_i = num; spr_wdata_i = d; spr_priv_i = priv;
    @(posedge clk);
    if (num == 10'd704) m_state = d;
    if (num == 10'd720 && priv) m_save = d;
    #1 spr_we_i = 0;
  endtask

  task automatic spr_rd(input logic [9:0] num, input logic priv, output logic [31:0] d, output logic e);
    @(negedge clk);
    spr_re_i = 1; spr_num_i = num; spr_priv_i = priv;
    #1 d = spr_rdata_o; e = spr_err_o;
    #1 spr_re_i = 0;
  endtask

  function automatic logic [NOPS*RW-1:0] exp_regs(input logic pf, input logic [NOPS*RW-1:0] b,
                                                 input logic [NOPS-1:0] v, input logic [RW-1:0] s);
    logic [NOPS*RW-1:0] r;
    for (int i = 0; i < NOPS; i++)
      r[i*RW +: RW] = (pf && v[i]) ? RW'((b[i*RW +: RW] + s) % 128) : b[i*RW +: RW];
    return r;
  endfunction

  task automatic run_instr(input logic pf, input logic [3:0] kind, input logic [NOPS*RW-1:0] regs,
                           input logic [NOPS-1:0] vec, input int stall_pct, input int exc_pct);
    bit done = 0, pend_rfi = 0;
    int guard = 0;
    while (!done && guard < 3000) begin
      logic rdy, ex, rf, bad, empty, ev, last, acc, er, eil;
      logic [RW-1:0] st, vl;
      string rid;
      guard++;
      @(negedge clk);
      rdy = ($urandom % 100) >= stall_pct;
      rf = pend_rfi;
      ex = !rf && (($urandom % 100) < exc_pct);
      pend_rfi = ex;
      dec_valid_i = 1; dec_prefixed_i = pf; dec_kind_i = kind; dec_reg_i = regs; dec_vec_i = vec;
      iss_ready_i = rdy; exc_i = ex; rfi_i = rf;
      #1;
      st = m_state[6:0]; vl = m_state[13:7];
      bad = pf && kind > 3;
      empty = pf && !bad && vl == 0;
      ev = !ex && !rf && !bad && !empty;
      last = ({1'b0, st} + 8'd1) >= {1'b0, vl};
      acc = ev && rdy;
      er = !ex && !rf && (bad || empty || (acc && (!pf || last)));
      eil = !ex && !rf && bad;
      rid = ex ? "R13" : rf ? "R10" : bad ? "R7" : empty ? "R5" : !pf ? "R8" : !rdy ? "R4" : "R2";
      check(rid, "iss_valid", 32'(iss_valid_o), 32'(ev));
      check(rid, "dec_ready", 32'(dec_ready_o), 32'(er));
      check(rid, "illegal", 32'(illegal_o), 32'(eil));
      if (ev) begin
        check("R3", "iss_reg", 32'(iss_reg_o), 32'(exp_regs(pf, regs, vec, st)));
        check(pf ? "R2" : "R8", "iss_step", 32'(iss_step_o), pf ? 32'(st) : 0);
      end
      @(posedge clk);
      if (ex) begin m_save = m_state; m_state[6:0] = 0; end
      else if (rf) m_state = m_save;
      else if (acc && pf) m_state[6:0] = last ? 7'd0 : st + 7'd1;
      if (er) done = 1;
    end
    @(negedge clk);
    dec_valid_i = 0; iss_ready_i = 0; exc_i = 0; rfi_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    check("R1", "iss_valid after reset", 32'(iss_valid_o), 0);
    spr_rd(10'd704, 0, d, e); check("R1", "loop state reset", d, 0);
    spr_rd(10'd720, 1, d, e); check("R1", "save reset", d, 0);

    // R11 full-width read back
    spr_wr(10'd704, {18'h2AF3C, 7'd5, 7'd0}, 0);
    spr_rd(10'd704, 0, d, e);
    check("R11", "loop state readback", d, m_state);
    check("R11", "no err on 704", 32'(e), 0);

    // R2/R3 basic loop, VL=5
    run_instr(1, 4'd0, {7'd3, 7'd10, 7'd20, 7'd30}, 4'b1010, 0, 0);
    spr_rd(10'd704, 0, d, e);
    check("R6", "step cleared, vl kept", d, {18'h2AF3C, 7'd5, 7'd0});

    // R3 wrap at 128
    spr_wr(10'd704, {18'd0, 7'd4, 7'd0}, 0);
    run_instr(1, 4'd1, {7'd126, 7'd127, 7'd5, 7'd125}, 4'b1101, 0, 0);

    // R4 stalls
    spr_wr(10'd704, {18'd0, 7'd6, 7'd0}, 0);
    run_instr(1, 4'd2, {7'd1, 7'd2, 7'd3, 7'd4}, 4'b1111, 70, 0);

    // R5 VL=0
    spr_wr(10'd704, 32'd0, 0);
    run_instr(1, 4'd0, {7'd9, 7'd9, 7'd9, 7'd9}, 4'b1111, 0, 0);

    // R7 every non-capable code, step untouched
    spr_wr(10'd704, {18'd0, 7'd6, 7'd2}, 0);
    for (int k = 4; k < 16; k++) run_instr(1, 4'(k), 28'h1234567, 4'b1111, 0, 0);
    spr_rd(10'd704, 0, d, e);
    check("R7", "state unchanged after illegal", d, {18'd0, 7'd6, 7'd2});

    // R8 unprefixed keeps state
    run_instr(0, 4'd0, {7'd50, 7'd60, 7'd70, 7'd80}, 4'b1111, 20, 0);
    spr_rd(10'd704, 0, d, e);
    check("R8", "state after unprefixed", d, {18'd0, 7'd6, 7'd2});

    // R9/R10/R13 directed trap mid-loop
    spr_wr(10'd704, {18'd0, 7'd8, 7'd3}, 0);
    @(negedge clk);
    dec_valid_i = 1; dec_prefixed_i = 1; dec_kind_i = 0; iss_ready_i = 1; exc_i = 1;
    #1;
    check("R13", "no offer during exc", 32'(iss_valid_o), 0);
    check("R13", "no retire during exc", 32'(dec_ready_o), 0);
    @(posedge clk);
    m_save = m_state; m_state[6:0] = 0;
    #1 exc_i = 0; dec_valid_i = 0; iss_ready_i = 0;
    spr_rd(10'd720, 1, d, e); check("R9", "saved step", d, {18'd0, 7'd8, 7'd3});
    spr_rd(10'd704, 0, d, e); check("R9", "live step cleared", d, {18'd0, 7'd8, 7'd0});
    @(negedge clk); rfi_i = 1;
    @(posedge clk); m_state = m_save;
    #1 rfi_i = 0;
    spr_rd(10'd704, 0, d, e); check("R10", "restored state", d, {18'd0, 7'd8, 7'd3});
    run_instr(1, 4'd3, {7'd100, 7'd0, 7'd64, 7'd2}, 4'b0111, 20, 0);

    // R12 privilege
    spr_wr(10'd720, 32'h0000_0ABC, 1);
    spr_wr(10'd720, 32'hFFFF_FFFF, 0);
    spr_rd(10'd720, 0, d, e);
    check("R12", "unpriv read data", d, 0);
    check("R12", "unpriv err", 32'(e), 1);
    spr_rd(10'd720, 1, d, e);
    check("R12", "unpriv write ignored", d, 32'h0000_0ABC);

    // random mix with traps in loops
    for (int it = 0; it < 60; it++) begin
      logic pf;
      logic [3:0] kind;
      pf = ($urandom % 8) != 0;
      kind = (($urandom % 5) == 0) ? 4'(4 + $urandom % 12) : 4'($urandom % 4);
      spr_wr(10'd704, {18'd0, 7'($urandom % 13), 7'd0}, 0);
      run_instr(pf, kind, 28'($urandom), 4'($urandom), 30, 6);
      spr_rd(10'd704, 0, d, e);
      check("R6", "random end state", d, m_state);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule